// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block draws a 64x64 two-plane cursor over a stream of video pixels. Each incoming pixel carries its screen column and row. When the cursor is enabled and the pixel lies inside the cursor window, the block fetches the matching mask bit pair from a small internal pattern store and replaces the pixel with cursor colour 0, cursor colour 1, the inverted pixel, or leaves it untouched. Every result appears one clock after its input pixel.

A host loads the pattern store through a word write port and programs position, clip offsets, colours and control through a byte register port. Position writes go into shadow registers. Writing the row-high byte snapshots the whole set into a pending copy, and the pending copy becomes active only while vertical blank is asserted. A cursor move therefore never tears a visible frame. Clip offsets select the first pattern column and row to draw, so a cursor hanging off the left or top edge is drawn with its origin at 0. Setting the row offset to 63 shows only the last pattern row, which software keeps transparent, and this hides the cursor without touching the enable bit.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `px_out` are 0; the cursor comes out of reset disabled, at origin (0,0) with zero clip offsets, colour 0 = 0x00 and colour 1 = all ones.
- R2: `out_valid` and `px_out` in a cycle reflect `px_valid` and `px_in` from the previous cycle; when `px_valid` is 0 the output pixel is the input pixel.
- R3: While the enable bit (register 6, bit 0) is 0, every pixel passes through unchanged.
- R4: Pattern word address = row*8 + 2*j + p, where j (0..3) selects columns 16j..16j+15, p=0 is the AND plane and p=1 the XOR plane; bit 15 of a word is the leftmost of its 16 columns.
- R5: A pattern bit pair (AND,XOR) of (1,0) passes the pixel, (0,0) outputs colour 0, (0,1) outputs colour 1, and (1,1) outputs the bitwise inverse of the pixel.
- R6: A pixel at (x,y) is in the window when x >= OX, y >= OY, x-OX+DX < 64 and y-OY+DY < 64, where OX,OY is the active origin and DX,DY the active clip offsets (low 6 bits); it then uses pattern column x-OX+DX and row y-OY+DY. Other pixels pass through.
- R7: Non-zero clip offsets start drawing at pattern column DX and row DY at the origin, shrinking the window to 64-DX columns and 64-DY rows.
- R8: Register map: 0 column high, 1 column low, 2 row low, 3 DX, 4 DY, 5 row high. Writes to 0..4 only fill shadow registers; without a later write to 5 they never change the drawn cursor.
- R9: A write to register 5 snapshots all six values into a pending set; the pending set becomes active at the first clock edge at which `vblank` is 1, from the following cycle on, and never while `vblank` is 0.
- R10: With DY = 63 only pattern row 63 is drawn, on screen row OY; when that row is transparent the cursor is invisible while still enabled.
- R11: When the scale bit (register 6, bit 1) is 1, the horizontal origin used is twice the programmed column value.
- R12: Registers 7 and 8 set colour 0 and colour 1; registers 6, 7 and 8 take effect in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index (see R8, R11, R12) |
| reg_wdata | input | 8 | Register write byte |
| pat_we | input | 1 | Pattern store write strobe |
| pat_addr | input | 9 | Pattern word address (see R4) |
| pat_wdata | input | 16 | Pattern word |
| vblank | input | 1 | Vertical blank indication |
| px_valid | input | 1 | Input pixel is an active display pixel |
| px_x | input | COORD_W | Screen column of the input pixel |
| px_y | input | COORD_W | Screen row of the input pixel |
| px_in | input | PIX_W | Underlying pixel value |
| out_valid | output | 1 | Output pixel valid, one cycle after `px_valid` |
| px_out | output | PIX_W | Pixel with cursor applied |

## Verification
The properties take for granted that the host never changes the position while the pending set is being applied in a way that matters to the frame, and that `vblank` is only raised between frames; the stimulus raises `vblank` only between pixel scans and never scans pixels while it is high. The checks on the active set also assume a single register write per cycle, which the write tasks guarantee by leaving an idle cycle after each strobe. Pixel coordinates stay within the screen range so that origin arithmetic never wraps.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int PIX_W   = 8,
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [3:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  input  logic               pat_we,
  input  logic [8:0]         pat_addr,
  input  logic [15:0]        pat_wdata,
  input  logic               vblank,
  input  logic               px_valid,
  input  logic [COORD_W-1:0] px_x,
  input  logic [COORD_W-1:0] px_y,
  input  logic [PIX_W-1:0]   px_in,
  output logic               out_valid,
  output logic [PIX_W-1:0]   px_out
);
  localparam int DIM    = 64;
  localparam int WORDS  = 512;
  localparam logic [3:0] A_XHI = 4'd0, A_XLO = 4'd1, A_YLO = 4'd2, A_DX = 4'd3,
                         A_DY = 4'd4, A_YHI = 4'd5, A_CTRL = 4'd6, A_COL0 = 4'd7,
                         A_COL1 = 4'd8;

  logic [7:0]         sh_xh, sh_xl, sh_yl;
  logic [5:0]         sh_dx, sh_dy;
  logic [COORD_W-1:0] pd_x, pd_y, act_x, act_y;
  logic [5:0]         pd_dx, pd_dy, act_dx, act_dy;
  logic               pend, en, scale;
  logic [PIX_W-1:0]   col0, col1, nxt;
  logic [15:0]        pat [0:WORDS-1];

  wire commit = reg_we && reg_addr == A_YHI;
  wire apply  = pend && vblank;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_xh <= '0; sh_xl <= '0; sh_yl <= '0; sh_dx <= '0; sh_dy <= '0;
      pd_x <= '0; pd_y <= '0; pd_dx <= '0; pd_dy <= '0; pend <= 1'b0;
      act_x <= '0; act_y <= '0; act_dx <= '0; act_dy <= '0;
      en <= 1'b0; scale <= 1'b0; col0 <= '0; col1 <= '1;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          A_XHI:  sh_xh <= reg_wdata;
          A_XLO:  sh_xl <= reg_wdata;
          A_YLO:  sh_yl <= reg_wdata;
          A_DX:   sh_dx <= reg_wdata[5:0];
          A_DY:   sh_dy <= reg_wdata[5:0];
          A_CTRL: begin en <= reg_wdata[0]; scale <= reg_wdata[1]; end
          A_COL0: col0 <= PIX_W'(reg_wdata);
          A_COL1: col1 <= PIX_W'(reg_wdata);
          default: ;
        endcase
      end
      if (apply) begin
        act_x <= pd_x; act_y <= pd_y; act_dx <= pd_dx; act_dy <= pd_dy;
      end
      if (commit) begin
        pd_x  <= COORD_W'({sh_xh, sh_xl});
        pd_y  <= COORD_W'({reg_wdata, sh_yl});
        pd_dx <= sh_dx;
        pd_dy <= sh_dy;
        pend  <= 1'b1;
      end else if (apply) begin
        pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pat_we) pat[pat_addr] <= pat_wdata;
  end

  logic [COORD_W-1:0] org_x;
  logic [COORD_W:0]   rel_x, rel_y, cx, cy;
  logic               hit, b_and, b_xor;
  logic [15:0]        w_and, w_xor;

  assign org_x = scale ? {act_x[COORD_W-2:0], 1'b0} : act_x;
  assign rel_x = {1'b0, px_x} - {1'b0, org_x};
  assign rel_y = {1'b0, px_y} - {1'b0, act_y};
  assign cx    = {1'b0, rel_x[COORD_W-1:0]} + {{(COORD_W-5){1'b0}}, act_dx};
  assign cy    = {1'b0, rel_y[COORD_W-1:0]} + {{(COORD_W-5){1'b0}}, act_dy};
  assign hit   = !rel_x[COORD_W] && !rel_y[COORD_W] &&
                 cx < (COORD_W+1)'(DIM) && cy < (COORD_W+1)'(DIM);
  assign w_and = pat[{cy[5:0], cx[5:4], 1'b0}];
  assign w_xor = pat[{cy[5:0], cx[5:4], 1'b1}];
  assign b_and = w_and[~cx[3:0]];
  assign b_xor = w_xor[~cx[3:0]];

  always_comb begin
    case ({b_and, b_xor})
      2'b00:   nxt = col0;
      2'b01:   nxt = col1;
      2'b10:   nxt = px_in;
      default: nxt = ~px_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      px_out    <= '0;
    end else begin
      out_valid <= px_valid;
      px_out    <= (px_valid && en && hit) ? nxt : px_in;
    end
  end
endmodule

module cursor_overlay_chk #(
  parameter int PIX_W   = 8,
  parameter int COORD_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_we,
  input logic [3:0]         reg_addr,
  input logic               vblank,
  input logic               px_valid,
  input logic [PIX_W-1:0]   px_in,
  input logic               out_valid,
  input logic [PIX_W-1:0]   px_out,
  input logic               en,
  input logic               pend,
  input logic [COORD_W-1:0] act_x,
  input logic [COORD_W-1:0] act_y,
  input logic [5:0]         act_dx,
  input logic [5:0]         act_dy
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    px_valid |=> out_valid);
  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !px_valid |=> (!out_valid && px_out == $past(px_in)));
  // R3
  disabled_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> px_out == $past(px_in));
  // R9
  no_tear_chk: assert property (@(posedge clk) disable iff (rst)
    !vblank |=> ($stable(act_x) && $stable(act_y) && $stable(act_dx) && $stable(act_dy)));
  // R9
  commit_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 4'd5) |=> pend);
  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend && !(reg_we && reg_addr == 4'd5)) |=> !pend);
  // R8
  idle_active_chk: assert property (@(posedge clk) disable iff (rst)
    !pend |=> ($stable(act_x) && $stable(act_y) && $stable(act_dx) && $stable(act_dy)));
endmodule

bind cursor_overlay cursor_overlay_chk #(.PIX_W(PIX_W), .COORD_W(COORD_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .vblank(vblank),
  .px_valid(px_valid), .px_in(px_in), .out_valid(out_valid), .px_out(px_out),
  .en(en), .pend(pend), .act_x(act_x), .act_y(act_y), .act_dx(act_dx), .act_dy(act_dy)
);

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 8;
  localparam int COORD_W = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0, pat_we = 1'b0, vblank = 1'b0, px_valid = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [8:0] pat_addr = '0;
  logic [15:0] pat_wdata = '0;
  logic [COORD_W-1:0] px_x = '0, px_y = '0;
  logic [PIX_W-1:0] px_in = '0;
  logic out_valid;
  logic [PIX_W-1:0] px_out;

  cursor_overlay #(.PIX_W(PIX_W), .COORD_W(COORD_W)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pat_we(pat_we), .pat_addr(pat_addr), .pat_wdata(pat_wdata), .vblank(vblank),
    .px_valid(px_valid), .px_x(px_x), .px_y(px_y), .px_in(px_in),
    .out_valid(out_valid), .px_out(px_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  // reference model state
  int m_pat [512];
  int sh [5];
  int pd_x, pd_y, pd_dx, pd_dy, a_x, a_y, a_dx, a_dy;
  int m_en, m_scale, m_c0, m_c1;
  bit m_pend, started;
  int exp_v, exp_px;

  function automatic int ref_pix(int x, int y, int pin);
    int ox, oy, c, r, wa, wx, bi, ba, bx;
    ox = m_scale ? (a_x * 2) % 4096 : a_x;
    oy = a_y;
    if (x < ox || y < oy) return pin;
    c = x - ox + a_dx;
    r = y - oy + a_dy;
    if (c >= 64 || r >= 64) return pin;
    wa = m_pat[r*8 + (c/16)*2];
    wx = m_pat[r*8 + (c/16)*2 + 1];
    bi = 15 - (c % 16);
    ba = (wa >> bi) & 1;
    bx = (wx >> bi) & 1;
    if (ba == 0 && bx == 0) return m_c0;
    if (ba == 0) return m_c1;
    if (bx == 0) return pin;
    return (~pin) & 255;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      foreach (sh[i]) sh[i] = 0;
      pd_x = 0; pd_y = 0; pd_dx = 0; pd_dy = 0;
      a_x = 0; a_y = 0; a_dx = 0; a_dy = 0;
      m_en = 0; m_scale = 0; m_c0 = 0; m_c1 = 255; m_pend = 0;
      exp_v = 0; exp_px = 0;
    end else begin
      bit np;
      exp_v = px_valid;
      exp_px = (px_valid && m_en != 0) ? ref_pix(int'(px_x), int'(px_y), int'(px_in)) : int'(px_in);
      np = m_pend;
      if (m_pend && vblank) begin
        a_x = pd_x; a_y = pd_y; a_dx = pd_dx; a_dy = pd_dy; np = 0;
      end
      if (reg_we) begin
        int d;
        d = int'(reg_wdata);
        case (int'(reg_addr))
          0, 1, 2, 3, 4: sh[int'(reg_addr)] = d;
          5: begin
            pd_x = (sh[0]*256 + sh[1]) % 4096;
            pd_y = (d*256 + sh[2]) % 4096;
            pd_dx = sh[3] % 64;
            pd_dy = sh[4] % 64;
            np = 1;
          end
          6: begin m_en = d & 1; m_scale = (d >> 1) & 1; end
          7: m_c0 = d;
          8: m_c1 = d;
          default: ;
        endcase
      end
      m_pend = np;
      if (pat_we) m_pat[int'(pat_addr)] = int'(pat_wdata);
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (out_valid !== exp_v[0] || px_out !== exp_px[PIX_W-1:0]) begin
        fails++;
        $display("FAIL %s: out_valid=%0d px_out=%02h expected out_valid=%0d px_out=%02h at t=%0t",
                 cur_req, out_valid, px_out, exp_v, exp_px, $time);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL %s: watchdog expired, actual cycles=%0d expected below 150000", cur_req, cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[3:0]; reg_wdata = d[7:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic int code_of(int r, int c);
    if (r == 63) return 2;
    return (r*7 + c*3 + r/4) % 4;
  endfunction

  // R4: word address = row*8 + 2*j + plane, bit 15 = leftmost column
  task automatic load_pattern();
    for (int w = 0; w < 512; w++) begin
      int r, j, p, word;
      r = w / 8; j = (w % 8) / 2; p = w % 2; word = 0;
      for (int b = 0; b < 16; b++) begin
        int cd;
        cd = code_of(r, 16*j + (15 - b));
        if (((p == 0) ? (cd >> 1) : cd) & 1) word |= (1 << b);
      end
      @(negedge clk);
      pat_we = 1'b1; pat_addr = w[8:0]; pat_wdata = word[15:0];
    end
    @(negedge clk);
    pat_we = 1'b0;
  endtask

  task automatic pulse_vblank();
    @(negedge clk); vblank = 1'b1;
    @(negedge clk);
    @(negedge clk); vblank = 1'b0;
  endtask

  task automatic move(input int x, input int y, input int dx, input int dy);
    wr_reg(0, x >> 8); wr_reg(1, x & 255); wr_reg(2, y & 255);
    wr_reg(3, dx); wr_reg(4, dy); wr_reg(5, y >> 8);
    pulse_vblank();
  endtask

  task automatic scan(input int x0, input int x1, input int y0, input int y1);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) begin
        @(negedge clk);
        px_valid = ((x + y) % 7) != 0;
        px_x = x[COORD_W-1:0]; px_y = y[COORD_W-1:0];
        px_in = PIX_W'(x*5 + y*3);
      end
    @(negedge clk);
    px_valid = 1'b0;
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || px_out !== '0) begin
      fails++;
      $display("FAIL R1: out_valid=%0d px_out=%02h expected 0/00", out_valid, px_out);
    end
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R4";
    load_pattern();

    cur_req = "R3";
    move(20, 20, 0, 0);
    scan(15, 90, 15, 25);

    cur_req = "R12";
    wr_reg(7, 8'h3C); wr_reg(8, 8'hA5); wr_reg(6, 1);
    cur_req = "R4 R5 R6 R12";
    scan(15, 90, 15, 88);

    cur_req = "R7";
    move(0, 0, 10, 5);
    scan(0, 70, 0, 66);

    cur_req = "R10";
    move(30, 30, 0, 63);
    scan(25, 100, 25, 35);

    cur_req = "R11";
    wr_reg(6, 3);
    move(40, 10, 0, 0);
    scan(70, 150, 8, 20);
    wr_reg(6, 1);

    cur_req = "R8";
    move(50, 40, 0, 0);
    @(negedge clk); vblank = 1'b1;
    wr_reg(0, 0); wr_reg(1, 200); wr_reg(2, 100); wr_reg(3, 3); wr_reg(4, 2);
    @(negedge clk); vblank = 1'b0;
    scan(45, 120, 38, 50);

    cur_req = "R9";
    wr_reg(5, 0);
    scan(45, 120, 38, 44);
    pulse_vblank();
    scan(195, 270, 98, 110);

    cur_req = "R2";
    scan(190, 210, 95, 100);

    cur_req = "R3";
    wr_reg(6, 0);
    scan(195, 230, 98, 104);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule